// File: doc/BRIEF.md
# Configurable Asynchronous Serial Framer

This block sends and receives characters over a three-wire asynchronous link that has one transmit line, one receive line and a shared ground, with no handshake wires. No clock travels with the data, so both ends agree on a bit rate in advance. On the system side, a byte-wide valid/ready port feeds the transmitter. The receiver returns each character as a one-cycle strobe that carries the data and two error flags.

A shared configuration sets the character shape for both directions. It selects 5 to 8 data bits, one of five parity modes, and a stop length of one, one and a half, or two bit times. A free-running divider produces an oversampling tick at 16 ticks per bit. All bit timing is counted in these ticks, so the half-bit stop length is exactly 24 ticks. The transmitter has a single holding register. It can accept the next byte during the final half bit of a stop period, so characters can run back to back with no gap. The receiver re-samples a falling edge at mid-bit before it treats the edge as a start bit.

Top module: `async_framer`

## Requirements
- R1: While reset is asserted and right after it, `txd` is 1, `tx_ready` is 1 and `rx_valid` is 0.
- R2: A transmitted character is one low start bit, then the data bits with bit 0 first, then the parity bit if one is configured, then high stop bits. The line rests high between characters.
- R3: `cfg_len` code n selects n+5 data bits (0 means 5 bits, 3 means 8 bits). The received data is right-aligned, and bits at or above the character length read 0.
- R4: `cfg_par` codes: 0 means no parity bit. 1 is odd (data plus parity has an odd count of ones). 2 is even. 3 always sends 1. 4 always sends 0. Codes 5 to 7 act as 0.
- R5: `cfg_stop` codes: 0 gives 16 ticks, 1 gives 24 ticks and 2 or 3 gives 32 ticks of stop time. With a byte already held, the next start bit begins exactly when the stop time ends.
- R6: Every start, data and parity bit lasts 16 ticks, and each tick is `CLKS_PER_TICK` clock cycles. Every falling edge of `txd` follows a tick.
- R7: `tx_ready` is high only when the holding register is empty and the transmitter is either idle or in the last 8 ticks of its stop time. After a byte is accepted, `tx_ready` drops on the next cycle.
- R8: If `rxd` goes low for less than half a bit and then returns high, no character is produced.
- R9: `rx_frame_err` is set with a character when the first stop bit samples low. The data is still delivered.
- R10: `rx_parity_err` is set when the received parity bit differs from the configured mode's value. It is never set when parity is off.
- R11: `rx_valid` is a single-cycle pulse. `rx_data`, `rx_frame_err` and `rx_parity_err` are meaningful in that cycle, and the error flags are low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 2 | Data length code (n+5 bits) |
| cfg_par | input | 3 | Parity mode code |
| cfg_stop | input | 2 | Stop length code |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_valid | output | 1 | Received character strobe |
| rx_data | output | 8 | Received character, right-aligned |
| rx_frame_err | output | 1 | Stop bit sampled low |
| rx_parity_err | output | 1 | Parity mismatch |

## Verification
A transmitted character starts on the first tick after acceptance. Each bit edge then comes every 16 ticks, which is 64 clocks with the default divider. The bench finds the start edge and samples `txd` at each bit centre, 32 clocks into the bit. It then counts clocks from the first stop-bit centre to the next start edge, which must be the stop length minus 8 ticks. The receiver's strobe comes a few ticks after the stop-bit centre, because of the two-flop synchronizer and tick phase. For that reason the bench reads received results only after waiting at least two further bit times, so results do not depend on exact receive latency.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam int unsigned OVS = 16;

  localparam logic [2:0] PAR_NONE = 3'd0;
  localparam logic [2:0] PAR_ODD  = 3'd1;
  localparam logic [2:0] PAR_EVEN = 3'd2;
  localparam logic [2:0] PAR_ONE  = 3'd3;
  localparam logic [2:0] PAR_ZERO = 3'd4;

  function automatic logic [3:0] data_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  function automatic logic [5:0] stop_ticks(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic par_used(input logic [2:0] mode);
    return (mode >= PAR_ODD) && (mode <= PAR_ZERO);
  endfunction

  function automatic logic par_value(input logic [7:0] d, input logic [1:0] len,
                                     input logic [2:0] mode);
    logic x;
    x = ^(d & (8'hFF >> (2'd3 - len)));
    case (mode)
      PAR_ODD:  return ~x;
      PAR_EVEN: return x;
      PAR_ONE:  return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sfr_tick_gen.sv
module sfr_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == W'(DIV - 1));
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sfr_tx.sv
module sfr_tx
  import sfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] cfg_len,
  input  logic [2:0] cfg_par,
  input  logic [1:0] cfg_stop,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       txd
);
  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_st_e;

  localparam logic [5:0] BIT_END = 6'(OVS - 1);

  tx_st_e     state_q, state_d;
  logic [5:0] tcnt_q, tcnt_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] shf_q, shf_d, hold_q, hold_d;
  logic       hfull_q, hfull_d;
  logic [1:0] len_q, len_d, stop_q, stop_d;
  logic [2:0] par_q, par_d;
  logic       pbit_q, pbit_d;
  logic       txd_q, txd_d;
  logic       accept, load;

  assign in_ready = !hfull_q && (state_q == TX_IDLE ||
                    (state_q == TX_STOP && tcnt_q >= stop_ticks(stop_q) - 6'd8));
  assign accept   = in_valid && in_ready;
  assign txd      = txd_q;

  always_comb begin
    state_d = state_q; tcnt_d = tcnt_q; bit_d = bit_q; shf_d = shf_q;
    hold_d  = hold_q;  hfull_d = hfull_q; len_d = len_q; par_d = par_q;
    stop_d  = stop_q;  pbit_d = pbit_q;  txd_d = txd_q; load = 1'b0;
    if (accept) begin
      hold_d  = in_data;
      hfull_d = 1'b1;
    end
    if (tick) begin
      case (state_q)
        TX_IDLE: load = hfull_q;
        TX_START:
          if (tcnt_q == BIT_END) begin
            tcnt_d = '0; state_d = TX_DATA; bit_d = '0; txd_d = shf_q[0];
          end else tcnt_d = tcnt_q + 6'd1;
        TX_DATA:
          if (tcnt_q == BIT_END) begin
            tcnt_d = '0;
            if ({1'b0, bit_q} == data_bits(len_q) - 4'd1) begin
              if (par_used(par_q)) begin state_d = TX_PAR;  txd_d = pbit_q; end
              else                 begin state_d = TX_STOP; txd_d = 1'b1;   end
            end else begin
              bit_d = bit_q + 3'd1; shf_d = shf_q >> 1; txd_d = shf_q[1];
            end
          end else tcnt_d = tcnt_q + 6'd1;
        TX_PAR:
          if (tcnt_q == BIT_END) begin
            tcnt_d = '0; state_d = TX_STOP; txd_d = 1'b1;
          end else tcnt_d = tcnt_q + 6'd1;
        TX_STOP:
          if (tcnt_q == stop_ticks(stop_q) - 6'd1) begin
            if (hfull_q) load = 1'b1;
            else begin state_d = TX_IDLE; tcnt_d = '0; end
          end else tcnt_d = tcnt_q + 6'd1;
        default: state_d = TX_IDLE;
      endcase
      if (load) begin
        state_d = TX_START; tcnt_d = '0; txd_d = 1'b0; shf_d = hold_q;
        hfull_d = 1'b0; len_d = cfg_len; par_d = cfg_par; stop_d = cfg_stop;
        pbit_d  = par_value(hold_q, cfg_len, cfg_par);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE; tcnt_q <= '0; bit_q <= '0; shf_q <= '0;
      hold_q  <= '0; hfull_q <= 1'b0; len_q <= '0; par_q <= '0;
      stop_q  <= '0; pbit_q <= 1'b0; txd_q <= 1'b1;
    end else begin
      state_q <= state_d; tcnt_q <= tcnt_d; bit_q <= bit_d; shf_q <= shf_d;
      hold_q  <= hold_d; hfull_q <= hfull_d; len_q <= len_d; par_q <= par_d;
      stop_q  <= stop_d; pbit_q <= pbit_d; txd_q <= txd_d;
    end
  end

  // R7
  tx_accept_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R6
  tx_edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd_q) |-> $past(tick));
  // R2
  tx_idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_IDLE) |-> txd_q);
endmodule

// File: rtl/sfr_rx.sv
module sfr_rx
  import sfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic [2:0] cfg_par,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_ferr,
  output logic       out_perr
);
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_st_e;

  localparam logic [3:0] BIT_END = 4'(OVS - 1);
  localparam logic [3:0] MID_END = 4'(OVS / 2 - 1);

  logic       s1_q, s2_q;
  rx_st_e     state_q, state_d;
  logic [3:0] cnt_q, cnt_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] data_q, data_d, odata_q, odata_d;
  logic [1:0] len_q, len_d;
  logic [2:0] par_q, par_d;
  logic       perr_q, perr_d, valid_q, valid_d, fe_q, fe_d, pe_q, pe_d;

  always_comb begin
    state_d = state_q; cnt_d = cnt_q; bit_d = bit_q; data_d = data_q;
    len_d = len_q; par_d = par_q; perr_d = perr_q;
    odata_d = odata_q; valid_d = 1'b0; fe_d = 1'b0; pe_d = 1'b0;
    if (tick) begin
      case (state_q)
        RX_IDLE:
          if (!s2_q) begin
            state_d = RX_START; cnt_d = '0; data_d = '0; perr_d = 1'b0;
            len_d = cfg_len; par_d = cfg_par;
          end
        RX_START:
          if (cnt_q == MID_END) begin
            cnt_d = '0; bit_d = '0;
            state_d = s2_q ? RX_IDLE : RX_DATA;
          end else cnt_d = cnt_q + 4'd1;
        RX_DATA:
          if (cnt_q == BIT_END) begin
            cnt_d = '0; data_d[bit_q] = s2_q;
            if ({1'b0, bit_q} == data_bits(len_q) - 4'd1)
              state_d = par_used(par_q) ? RX_PAR : RX_STOP;
            else bit_d = bit_q + 3'd1;
          end else cnt_d = cnt_q + 4'd1;
        RX_PAR:
          if (cnt_q == BIT_END) begin
            cnt_d = '0; state_d = RX_STOP;
            perr_d = (s2_q != par_value(data_q, len_q, par_q));
          end else cnt_d = cnt_q + 4'd1;
        RX_STOP:
          if (cnt_q == BIT_END) begin
            cnt_d = '0; state_d = RX_IDLE; valid_d = 1'b1; odata_d = data_q;
            fe_d = !s2_q; pe_d = par_used(par_q) && perr_q;
          end else cnt_d = cnt_q + 4'd1;
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1; s2_q <= 1'b1;
      state_q <= RX_IDLE; cnt_q <= '0; bit_q <= '0; data_q <= '0;
      len_q <= '0; par_q <= '0; perr_q <= 1'b0;
      odata_q <= '0; valid_q <= 1'b0; fe_q <= 1'b0; pe_q <= 1'b0;
    end else begin
      s1_q <= rxd; s2_q <= s1_q;
      state_q <= state_d; cnt_q <= cnt_d; bit_q <= bit_d; data_q <= data_d;
      len_q <= len_d; par_q <= par_d; perr_q <= perr_d;
      odata_q <= odata_d; valid_q <= valid_d; fe_q <= fe_d; pe_q <= pe_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = odata_q;
  assign out_ferr  = fe_q;
  assign out_perr  = pe_q;

  // R11
  rx_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R10
  rx_perr_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_perr |-> out_valid);
  // R9
  rx_ferr_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ferr |-> out_valid);
  // R3
  rx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && len_q == 2'd0) |-> (out_data[7:5] == 3'b000));
endmodule

// File: rtl/async_framer.sv
module async_framer
  import sfr_pkg::*;
#(
  parameter int unsigned CLKS_PER_TICK = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_len,
  input  logic [2:0] cfg_par,
  input  logic [1:0] cfg_stop,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic       txd,
  input  logic       rxd,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_frame_err,
  output logic       rx_parity_err
);
  logic rs1_q, rs2_q, tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rs1_q <= 1'b0; rs2_q <= 1'b0; end
    else        begin rs1_q <= 1'b1; rs2_q <= rs1_q; end
  end

  sfr_tick_gen #(.DIV(CLKS_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rs2_q), .tick(tick));

  sfr_tx u_tx (
    .clk(clk), .rst_n(rs2_q), .tick(tick),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
    .in_valid(tx_valid), .in_data(tx_data), .in_ready(tx_ready), .txd(txd));

  sfr_rx u_rx (
    .clk(clk), .rst_n(rs2_q), .tick(tick), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par(cfg_par),
    .out_valid(rx_valid), .out_data(rx_data),
    .out_ferr(rx_frame_err), .out_perr(rx_parity_err));
endmodule

// File: tb/async_framer_tb.sv
`timescale 1ns/1ps
module async_framer_tb;
  localparam int DIV = 4;
  localparam int BITC = 16 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_len = 2'd3;
  logic [2:0] cfg_par = 3'd0;
  logic [1:0] cfg_stop = 2'd0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic loop_en = 1'b1;
  logic bench_rx = 1'b1;
  logic tx_ready, txd, rx_valid, rx_frame_err, rx_parity_err, rxd_w;
  logic [7:0] rx_data;

  int checks = 0, errors = 0;
  int rx_cnt = 0;
  logic [7:0] rx_last = 0, rx_prev = 0;
  logic rx_fe = 0, rx_pe = 0;

  always #4 clk = ~clk;
  assign rxd_w = loop_en ? txd : bench_rx;

  async_framer #(.CLKS_PER_TICK(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_par(cfg_par),
    .cfg_stop(cfg_stop), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .txd(txd), .rxd(rxd_w), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_frame_err(rx_frame_err),
    .rx_parity_err(rx_parity_err));

  always @(negedge clk) if (rx_valid) begin
    rx_cnt++; rx_prev = rx_last; rx_last = rx_data;
    rx_fe = rx_frame_err; rx_pe = rx_parity_err;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_par(input logic [7:0] d, input int n, input logic [2:0] m);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += d[i];
    case (m)
      3'd1: return (ones % 2) == 0;
      3'd2: return (ones % 2) == 1;
      3'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int stop_len(input logic [1:0] s);
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 24 : 32;
  endfunction

  task automatic push(input logic [7:0] d);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // Observe one transmitted character at bit centres (R2, R4, R5, R6, R7)
  task automatic mon_frame(input logic [7:0] d, input int n, input logic [2:0] p,
                           input logic [1:0] s, input bit measure);
    int gap;
    while (txd !== 1'b0) @(negedge clk);
    repeat (BITC / 2) @(negedge clk);
    chk(txd == 1'b0, "R6", "start bit low at centre", txd, 0);
    chk(tx_ready == 1'b0, "R7", "ready low mid-frame", tx_ready, 0);
    for (int i = 0; i < n; i++) begin
      repeat (BITC) @(negedge clk);
      chk(txd == d[i], "R2", $sformatf("data bit %0d", i), txd, d[i]);
    end
    if (p >= 3'd1 && p <= 3'd4) begin
      repeat (BITC) @(negedge clk);
      chk(txd == exp_par(d, n, p), "R4", "parity bit", txd, exp_par(d, n, p));
    end
    repeat (BITC) @(negedge clk);
    chk(txd == 1'b1, "R2", "stop bit high", txd, 1);
    if (measure) begin
      gap = 0;
      while (txd == 1'b1) begin @(negedge clk); gap++; end
      chk(gap == (stop_len(s) - 8) * DIV, "R5", "stop to next start clocks",
          gap, (stop_len(s) - 8) * DIV);
    end
  endtask

  task automatic tx_pair(input logic [1:0] len, input logic [2:0] p,
                         input logic [1:0] s, input logic [7:0] d0, input logic [7:0] d1);
    int n = len + 5;
    int c0;
    logic [7:0] mask = 8'hFF >> (8 - n);
    cfg_len = len; cfg_par = p; cfg_stop = s; loop_en = 1'b1;
    c0 = rx_cnt;
    fork
      begin push(d0); push(d1); end
      begin mon_frame(d0, n, p, s, 1'b1); mon_frame(d1, n, p, s, 1'b0); end
    join
    repeat (3 * BITC) @(negedge clk);
    chk(rx_cnt == c0 + 2, "R11", "received character count", rx_cnt, c0 + 2);
    chk(rx_prev == (d0 & mask), "R3", "loopback first char", rx_prev, d0 & mask);
    chk(rx_last == (d1 & mask), "R3", "loopback second char", rx_last, d1 & mask);
    chk(!rx_fe && !rx_pe, "R10", "no errors on clean loopback", {rx_fe, rx_pe}, 0);
  endtask

  task automatic drive_frame(input logic [7:0] d, input int n, input bit use_p,
                             input logic pb, input logic stopv);
    bench_rx = 1'b0; repeat (BITC) @(negedge clk);
    for (int i = 0; i < n; i++) begin bench_rx = d[i]; repeat (BITC) @(negedge clk); end
    if (use_p) begin bench_rx = pb; repeat (BITC) @(negedge clk); end
    bench_rx = stopv; repeat (BITC) @(negedge clk);
    bench_rx = 1'b1; repeat (3 * BITC) @(negedge clk);
  endtask

  task automatic test_reset;
    chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
    chk(tx_ready == 1'b1, "R1", "tx_ready after reset", tx_ready, 1);
    chk(rx_valid == 1'b0, "R1", "rx_valid after reset", rx_valid, 0);
  endtask

  task automatic test_glitch;
    int c0;
    loop_en = 1'b0; cfg_len = 2'd3; cfg_par = 3'd0;
    c0 = rx_cnt;
    bench_rx = 1'b0; repeat (5 * DIV) @(negedge clk);
    bench_rx = 1'b1; repeat (3 * BITC) @(negedge clk);
    chk(rx_cnt == c0, "R8", "short low pulse ignored", rx_cnt, c0);
    drive_frame(8'h3C, 8, 1'b0, 1'b0, 1'b1);
    chk(rx_cnt == c0 + 1 && rx_last == 8'h3C, "R8", "frame after glitch", rx_last, 8'h3C);
  endtask

  task automatic test_frame_err;
    int c0;
    loop_en = 1'b0; cfg_len = 2'd3; cfg_par = 3'd0;
    c0 = rx_cnt;
    drive_frame(8'h96, 8, 1'b0, 1'b0, 1'b0);
    chk(rx_cnt == c0 + 1, "R9", "one character on bad stop", rx_cnt, c0 + 1);
    chk(rx_fe == 1'b1, "R9", "framing error flag", rx_fe, 1);
    chk(rx_last == 8'h96, "R9", "data kept on framing error", rx_last, 8'h96);
  endtask

  task automatic test_parity_err;
    loop_en = 1'b0; cfg_len = 2'd3; cfg_par = 3'd2;
    drive_frame(8'h07, 8, 1'b1, ~exp_par(8'h07, 8, 3'd2), 1'b1);
    chk(rx_pe == 1'b1 && rx_fe == 1'b0, "R10", "even parity mismatch", {rx_fe, rx_pe}, 1);
    cfg_par = 3'd1;
    drive_frame(8'h07, 8, 1'b1, exp_par(8'h07, 8, 3'd1), 1'b1);
    chk(rx_pe == 1'b0, "R10", "odd parity correct", rx_pe, 0);
    cfg_len = 2'd2; cfg_par = 3'd0;
    drive_frame(8'h55, 7, 1'b0, 1'b0, 1'b1);
    chk(rx_pe == 1'b0 && rx_last == 8'h55, "R10", "no parity mode", rx_last, 8'h55);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    test_reset();
    tx_pair(2'd3, 3'd0, 2'd0, 8'hA5, 8'h5A);
    tx_pair(2'd0, 3'd1, 2'd1, 8'hFD, 8'h13);
    tx_pair(2'd2, 3'd2, 2'd2, 8'h71, 8'h2E);
    tx_pair(2'd1, 3'd3, 2'd3, 8'h2A, 8'h15);
    tx_pair(2'd3, 3'd4, 2'd1, 8'hC3, 8'h80);
    test_glitch();
    test_frame_err();
    test_parity_err();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule